// File: doc/BRIEF.md
# Eight-Channel Double-Ranked DAC Code Register File

This block is the digital control core that sits in front of an eight-channel converter with parallel inputs. Every channel keeps its code in two ranks. The first rank is a staging register. It is written one channel at a time through a channel address, a 13-bit data word and two active-low strobes, chip select and write. The second rank drives the converter. A single active-low load strobe copies every staged code into the second rank together, so all outputs change on the same cycle.

Each transparent latch is built as an enabled register that updates on every clock edge while its enable holds. The three strobes, the address and the data pass through a common synchroniser. An active-low clear masks every output to the mid-scale code while it is low. That code is the one that yields zero volts on an output swing centred on the midpoint reference. Clear uses no clock and leaves both ranks untouched, so the stored codes reappear as soon as clear is released.

Top module: `dac_bank_regfile`

## Requirements
- R1: After synchronous reset, every first-rank and second-rank register holds the mid-scale code 0x1000, and every output shows 0x1000.
- R2: While chip select and write are both low and load is high, the data word is stored in the first rank of the addressed channel only, and no output changes.
- R3: While load is low, every channel's second rank copies its first rank on each clock edge, and each output then shows that code.
- R4: Address value n selects channel n (000 selects channel 0, 111 selects channel 7, address bit 2 is the MSB). Channel n appears on code_o bits [13n+12:13n], and data bit 0 is the LSB of the code.
- R5: While chip select or write is high, no first-rank register changes. A later load therefore shows the earlier codes.
- R6: While load is high, the second rank and the outputs hold, even when the first rank is rewritten.
- R7: While chip select, write and load are all low, the data word passes through both ranks to the addressed channel's output in the same update.
- R8: While clr_n_i is low, every output equals 0x1000 within the same time step, with no clock edge needed.
- R9: Clear changes neither rank, and writes and loads made during clear are still stored. After clear is released, the outputs show the second-rank contents.
- R10: A write with load applied before rising edge k shows on the outputs after edge k+2 and not before. This latency comes from two synchroniser stages and one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 3 | Channel address, bit 2 is the MSB |
| data_i | input | 13 | Code word, bit 0 is the LSB |
| cs_n_i | input | 1 | Chip select, active low, level sensitive |
| wr_n_i | input | 1 | Write strobe, active low, level sensitive |
| ld_n_i | input | 1 | Load strobe to the second rank, active low |
| clr_n_i | input | 1 | Clear, active low, masks the outputs without a clock |
| code_o | output | 104 | Eight 13-bit output codes, channel n at bits [13n+12:13n] |

## Verification
A wrong first-rank value stays hidden until the next load, so the bench always follows staged writes with a load and then reads all eight outputs. An address decode fault or a write that should have been blocked then shows up as a wrong code on an unexpected channel, three edges after the load. A wrong second-rank value appears at the ports straight away. The only exception is while clear is low, so the bench also compares the outputs after clear is released. Every channel is swept with several data patterns in flow-through mode, and the sweep checks all eight outputs each time to catch cross-channel corruption.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  // Mid-scale code for a code word of the given width (MSB set, rest clear).
  function automatic int unsigned mid_code(input int unsigned width);
    return 32'd1 << (width - 1);
  endfunction
endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dacbank_decode.sv
module dacbank_decode #(
  parameter int CH = 8,
  parameter int AW = 3
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [CH-1:0] sel
);
  for (genvar c = 0; c < CH; c++) begin : g_sel
    assign sel[c] = en && (addr == AW'(c));
  end
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
  parameter int           CW       = 13,
  parameter logic [CW-1:0] RST_CODE = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          ld_en,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] in_q,
  output logic [CW-1:0] dac_q
);
  logic [CW-1:0] in_next;

  // Second rank follows the first rank's next value so that write and
  // load together pass data through both ranks in one update.
  always_comb in_next = wr_en ? din : in_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= RST_CODE;
      dac_q <= RST_CODE;
    end else begin
      in_q <= in_next;
      if (ld_en) dac_q <= in_next;
    end
  end
endmodule

// File: rtl/dac_bank_regfile.sv
module dac_bank_regfile #(
  parameter int CHANNELS    = 8,
  parameter int CODE_W      = 13,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(CHANNELS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [CODE_W-1:0]          data_i,
  input  logic                       cs_n_i,
  input  logic                       wr_n_i,
  input  logic                       ld_n_i,
  input  logic                       clr_n_i,
  output logic [CHANNELS*CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(dacbank_pkg::mid_code(CODE_W));
  localparam int PAY_W = ADDR_W + CODE_W;

  logic              cs_s_n, wr_s_n, ld_s_n;
  logic [ADDR_W-1:0] addr_s;
  logic [CODE_W-1:0] data_s;
  logic [CHANNELS-1:0] wr_sel;
  logic [CHANNELS*CODE_W-1:0] inp_flat;
  logic [CHANNELS*CODE_W-1:0] dac_flat;

  // Strobes idle high out of reset.
  dacbank_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_strobe_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n_i, wr_n_i, ld_n_i}),
    .q   ({cs_s_n, wr_s_n, ld_s_n})
  );

  // Address and data take the same path so they stay aligned to the strobes.
  dacbank_sync #(.W(PAY_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_payload_sync (
    .clk (clk),
    .rst (rst),
    .d   ({addr_i, data_i}),
    .q   ({addr_s, data_s})
  );

  dacbank_decode #(.CH(CHANNELS), .AW(ADDR_W)) u_decode (
    .en   (~cs_s_n & ~wr_s_n),
    .addr (addr_s),
    .sel  (wr_sel)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic [CODE_W-1:0] in_q, dac_q;

    dacbank_chan #(.CW(CODE_W), .RST_CODE(MID_CODE)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_sel[c]),
      .ld_en (~ld_s_n),
      .din   (data_s),
      .in_q  (in_q),
      .dac_q (dac_q)
    );

    assign inp_flat[c*CODE_W +: CODE_W] = in_q;
    assign dac_flat[c*CODE_W +: CODE_W] = dac_q;
    // Clear masks the output without a clock and leaves both ranks alone.
    assign code_o[c*CODE_W +: CODE_W]   = clr_n_i ? dac_q : MID_CODE;
  end
endmodule

// File: rtl/dac_bank_regfile_chk.sv
module dac_bank_regfile_chk #(
  parameter int CH = 8,
  parameter int CW = 13
) (
  input logic            clk,
  input logic            rst,
  input logic            clr_n_i,
  input logic            cs_s_n,
  input logic            wr_s_n,
  input logic            ld_s_n,
  input logic [CH*CW-1:0] inp_flat,
  input logic [CH*CW-1:0] dac_flat,
  input logic [CH*CW-1:0] code_o
);
  localparam logic [CW-1:0]    MID     = CW'(dacbank_pkg::mid_code(CW));
  localparam logic [CH*CW-1:0] MID_ALL = {CH{MID}};

  // R1: both ranks at mid-scale on the first cycle after reset
  a_r1_reset_mid: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (inp_flat == MID_ALL && dac_flat == MID_ALL));

  // R5: no first-rank change while either write strobe is inactive
  a_r5_no_write_when_idle: assert property (@(posedge clk) disable iff (rst)
    (cs_s_n || wr_s_n) |=> $stable(inp_flat));

  // R6: second rank holds while load is inactive
  a_r6_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    ld_s_n |=> $stable(dac_flat));

  // R8: clear forces every output to mid-scale
  a_r8_clear_masks: assert property (@(posedge clk) disable iff (rst)
    !clr_n_i |-> (code_o == MID_ALL));

  // R9: outside clear the outputs follow the second rank
  a_r9_outputs_follow_rank: assert property (@(posedge clk) disable iff (rst)
    clr_n_i |-> (code_o == dac_flat));
endmodule

bind dac_bank_regfile dac_bank_regfile_chk #(.CH(CHANNELS), .CW(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr_n_i  (clr_n_i),
  .cs_s_n   (cs_s_n),
  .wr_s_n   (wr_s_n),
  .ld_s_n   (ld_s_n),
  .inp_flat (inp_flat),
  .dac_flat (dac_flat),
  .code_o   (code_o)
);

// File: tb/tb_dac_bank_regfile.sv
module tb_dac_bank_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int CH  = 8;
  localparam int CW  = 13;
  localparam int AW  = 3;
  localparam logic [CW-1:0] MID = 13'h1000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [CW-1:0] data_i = '0;
  logic          cs_n_i = 1'b1, wr_n_i = 1'b1, ld_n_i = 1'b1, clr_n_i = 1'b1;
  logic [CH*CW-1:0] code_o;

  logic [CW-1:0] exp_in  [CH];
  logic [CW-1:0] exp_dac [CH];
  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  dac_bank_regfile dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .data_i(data_i),
    .cs_n_i(cs_n_i), .wr_n_i(wr_n_i), .ld_n_i(ld_n_i), .clr_n_i(clr_n_i),
    .code_o(code_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input int ch, input logic [CW-1:0] expv, input string tag);
    logic [CW-1:0] act;
    act = code_o[ch*CW +: CW];
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s ch%0d: actual %h expected %h", tag, ch, act, expv);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int c = 0; c < CH; c++) chk(c, clr_n_i ? exp_dac[c] : MID, tag);
  endtask

  // One-cycle strobe pulse, then enough idle cycles to flush the pipeline.
  task automatic pulse(input int a, input logic [CW-1:0] d,
                       input logic cs, input logic wr, input logic ld);
    addr_i = AW'(a); data_i = d; cs_n_i = cs; wr_n_i = wr; ld_n_i = ld;
    wait_neg(1);
    cs_n_i = 1'b1; wr_n_i = 1'b1; ld_n_i = 1'b1;
    if (!cs && !wr) exp_in[a] = d;
    if (!ld) for (int c = 0; c < CH; c++) exp_dac[c] = exp_in[c];
    wait_neg(4);
  endtask

  function automatic logic [CW-1:0] pat(input int c, input int k);
    return CW'(c * 677 + k * 1231 + 19);
  endfunction

  initial begin
    for (int c = 0; c < CH; c++) begin exp_in[c] = MID; exp_dac[c] = MID; end
    wait_neg(4);
    rst = 1'b0;
    wait_neg(1);
    chk_all("R1 reset");

    // R2/R4: stage distinct codes in every channel, outputs stay put
    for (int c = 0; c < CH; c++) pulse(c, pat(c, 1), 1'b0, 1'b0, 1'b1);
    chk_all("R2 staged write invisible");
    // R3/R4: load moves all staged codes at once
    pulse(0, '0, 1'b1, 1'b1, 1'b0);
    chk_all("R3 R4 load all channels");

    // R5: chip select high or write high blocks the write
    pulse(3, 13'h0abc, 1'b1, 1'b0, 1'b1);
    pulse(5, 13'h1def, 1'b0, 1'b1, 1'b1);
    pulse(0, '0, 1'b1, 1'b1, 1'b0);
    chk_all("R5 blocked write");

    // R6: rewrite first rank with load high, outputs hold
    pulse(2, 13'h0001, 1'b0, 1'b0, 1'b1);
    pulse(7, 13'h1fff, 1'b0, 1'b0, 1'b1);
    chk_all("R6 hold while load high");
    pulse(0, '0, 1'b1, 1'b1, 1'b0);
    chk_all("R6 R3 later load");

    // R10: latency of flow-through update
    addr_i = 3'd4; data_i = 13'h0777; cs_n_i = 0; wr_n_i = 0; ld_n_i = 0;
    wait_neg(1);
    cs_n_i = 1; wr_n_i = 1; ld_n_i = 1;
    wait_neg(1);
    chk(4, exp_dac[4], "R10 not yet after two edges");
    wait_neg(1);
    exp_in[4] = 13'h0777;
    for (int c = 0; c < CH; c++) exp_dac[c] = exp_in[c];
    chk(4, 13'h0777, "R10 visible after third edge");
    wait_neg(2);

    // R7/R4: sweep every address with several patterns in flow-through mode
    for (int k = 0; k < 6; k++) begin
      for (int c = 0; c < CH; c++) begin
        logic [CW-1:0] d;
        case (k)
          0: d = 13'h0000;
          1: d = 13'h1fff;
          2: d = 13'h1555;
          3: d = 13'h0aaa;
          4: d = 13'h1000;
          default: d = pat(c, k);
        endcase
        pulse(c, d, 1'b0, 1'b0, 1'b0);
        chk_all("R7 R4 flow-through sweep");
      end
    end

    // R8: clear masks outputs immediately
    clr_n_i = 1'b0;
    #1;
    chk_all("R8 clear immediate");
    // R9: writes and loads during clear are still stored
    pulse(6, 13'h0321, 1'b0, 1'b0, 1'b1);
    pulse(1, 13'h1234, 1'b0, 1'b0, 1'b0);
    chk_all("R8 clear held");
    clr_n_i = 1'b1;
    #1;
    chk_all("R9 restore after clear");
    wait_neg(2);
    chk_all("R9 stable after clear");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule